// File: doc/BRIEF.md
# Pseudo-Static RAM Write Strobe Sequencer

This block turns a one-cycle write request from a host into the chip-enable, write-enable and output-enable waveform that an asynchronous pseudo-static memory needs. It also drives the address, the write data and the data-bus direction. On acceptance it captures the address and data. It lowers the two strobes in a fixed order set by a parameter. It turns the data drivers on only once the memory's own outputs are certain to be off. It holds the data for a set number of clock cycles with both strobes low. Then it ends the write by raising one strobe and releasing the bus on the same clock edge.

Every analog limit is a whole number of system-clock cycles set by a parameter. The parameters cover the time the memory needs to float its outputs after write enable falls, and the time data must be valid before the write ends. A parameter chooses whether chip enable or write enable falls first, or whether both fall together. When chip enable falls with or after write enable, the memory's outputs never turn on, so the float wait is skipped. A second parameter chooses which strobe rises first to end the write. The host sees a ready flag and a one-cycle completion pulse. Output enable is held inactive for the whole time, so only write enable can gate the memory's outputs.

Top module: `psram_wr_gen`

## Requirements
- R1: An active-low asynchronous reset puts the block idle at once: chip enable, write enable and output enable high (inactive), bus drive off, ready high, completion pulse low.
- R2: A request is accepted only on a clock edge where req_valid and req_ready are both high. A request raised while req_ready is low has no effect on the address, the data or the strobe sequence. With no request, the strobes stay high.
- R3: mem_oe_n stays high (outputs disabled) in every cycle.
- R4: With the chip-enable-first order (STROBE_ORDER=0), chip enable falls on the accepting edge and write enable falls one edge later. Bus drive starts exactly WHZ_CYC edges after write enable falls.
- R5: With the write-enable-first order (STROBE_ORDER=1), write enable falls on the accepting edge. Chip enable falls one edge later, and bus drive starts on that same edge.
- R6: With the simultaneous order (STROBE_ORDER=2), both strobes fall and bus drive starts on the accepting edge.
- R7: Bus drive stays on for exactly DW_CYC cycles. During those cycles mem_dq_out carries the captured data and both strobes are low.
- R8: The write ends on one edge. On that edge the strobe chosen by END_BY_CE rises (chip enable if 1, write enable if 0) and bus drive turns off. The other strobe rises on the next edge.
- R9: mem_dq_drive is never high unless both chip enable and write enable are low.
- R10: req_ready falls on the accepting edge and rises one edge after chip enable rises. wr_done pulses high for exactly that one cycle.
- R11: mem_addr holds the captured address from the accepting edge until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host write request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_ready | output | 1 | Block can accept a request |
| wr_done | output | 1 | One-cycle pulse when a write has finished |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data toward the memory data bus |
| mem_dq_drive | output | 1 | High while the block drives the data bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |

## Verification
The bench builds three copies side by side. The first uses chip-enable-first order with WHZ_CYC=2, DW_CYC=3 and a write-enable end. The second uses write-enable-first order with DW_CYC=2 and a chip-enable end. The third uses the simultaneous order with WHZ_CYC=1, DW_CYC=1 and a write-enable end. Between them they cover every lead-in order, both end edges, the one-cycle minimum of the data window, and the extra recovery cycle that only a write-enable end needs. They also allow requests raised while busy, and a reset that lands in the middle of a write.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;

    localparam int unsigned ORD_CE_FIRST = 0;
    localparam int unsigned ORD_WE_FIRST = 1;
    localparam int unsigned ORD_TOGETHER = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HZ,
        ST_DATA,
        ST_TAIL,
        ST_REC
    } wr_state_e;

    typedef struct packed {
        wr_state_e state;
        logic      ce_n;
        logic      we_n;
        logic      oe_n;
        logic      drive;
        logic      ready;
        logic      done;
    } seq_regs_t;

endpackage

// File: rtl/psram_wr_capture.sv
module psram_wr_capture #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            cap_d.addr = in_addr;
            cap_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign out_addr = cap_q.addr;
    assign out_data = cap_q.data;

endmodule

// File: rtl/psram_wr_timer.sv
module psram_wr_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/psram_wr_fsm.sv
module psram_wr_fsm
    import psram_wr_pkg::*;
#(
    parameter int unsigned STROBE_ORDER = ORD_CE_FIRST,
    parameter bit          END_BY_CE    = 1'b0,
    parameter int unsigned WHZ_CYC      = 2,
    parameter int unsigned DW_CYC       = 2,
    parameter int unsigned CNT_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             tmr_expired,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             drive,
    output logic             ready,
    output logic             done
);

    localparam logic [CNT_W-1:0] HZ_LOAD = CNT_W'(WHZ_CYC - 1);
    localparam logic [CNT_W-1:0] DW_LOAD = CNT_W'(DW_CYC - 1);

    localparam seq_regs_t IDLE_REGS = '{
        state: ST_IDLE, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
        drive: 1'b0, ready: 1'b1, done: 1'b0
    };

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.oe_n = 1'b1;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = req_valid && r_q.ready;

        case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    r_d.ready = 1'b0;
                    if (STROBE_ORDER == ORD_CE_FIRST) begin
                        r_d.ce_n  = 1'b0;
                        r_d.state = ST_LEAD;
                    end else if (STROBE_ORDER == ORD_WE_FIRST) begin
                        r_d.we_n  = 1'b0;
                        r_d.state = ST_LEAD;
                    end else begin
                        r_d.ce_n  = 1'b0;
                        r_d.we_n  = 1'b0;
                        r_d.drive = 1'b1;
                        r_d.state = ST_DATA;
                        tmr_load  = 1'b1;
                        tmr_val   = DW_LOAD;
                    end
                end
            end
            ST_LEAD: begin
                if (STROBE_ORDER == ORD_CE_FIRST) begin
                    r_d.we_n  = 1'b0;
                    r_d.state = ST_HZ;
                    tmr_load  = 1'b1;
                    tmr_val   = HZ_LOAD;
                end else begin
                    r_d.ce_n  = 1'b0;
                    r_d.drive = 1'b1;
                    r_d.state = ST_DATA;
                    tmr_load  = 1'b1;
                    tmr_val   = DW_LOAD;
                end
            end
            ST_HZ: begin
                if (tmr_expired) begin
                    r_d.drive = 1'b1;
                    r_d.state = ST_DATA;
                    tmr_load  = 1'b1;
                    tmr_val   = DW_LOAD;
                end
            end
            ST_DATA: begin
                if (tmr_expired) begin
                    r_d.drive = 1'b0;
                    if (END_BY_CE) begin
                        r_d.ce_n = 1'b1;
                    end else begin
                        r_d.we_n = 1'b1;
                    end
                    r_d.state = ST_TAIL;
                end
            end
            ST_TAIL: begin
                r_d.ce_n = 1'b1;
                r_d.we_n = 1'b1;
                if (END_BY_CE) begin
                    r_d.ready = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.state = ST_REC;
                end
            end
            ST_REC: begin
                r_d.ready = 1'b1;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d = IDLE_REGS;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= IDLE_REGS;
        end else begin
            r_q <= r_d;
        end
    end

    assign ce_n  = r_q.ce_n;
    assign we_n  = r_q.we_n;
    assign oe_n  = r_q.oe_n;
    assign drive = r_q.drive;
    assign ready = r_q.ready;
    assign done  = r_q.done;

    // Cycle counters used only by the checks below
    int unsigned we_low_cyc_q;
    int unsigned drive_cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cyc_q <= 0;
            drive_cyc_q  <= 0;
        end else begin
            we_low_cyc_q <= r_q.we_n ? 0 : we_low_cyc_q + 1;
            drive_cyc_q  <= r_q.drive ? drive_cyc_q + 1 : 0;
        end
    end

    AST_DRIVE_IN_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.drive |-> (!r_q.we_n && !r_q.ce_n)); // R9

    AST_FLOAT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (STROBE_ORDER == ORD_CE_FIRST && $rose(r_q.drive)) |-> (we_low_cyc_q == WHZ_CYC)); // R4

    AST_DATA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.drive) |-> (drive_cyc_q == DW_CYC)); // R7

    AST_SINGLE_END_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.drive) |-> (r_q.ce_n != r_q.we_n) && (r_q.ce_n == END_BY_CE)); // R8

    AST_BOTH_HIGH_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.drive) |=> (r_q.ce_n && r_q.we_n)); // R8

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !r_q.ready); // R10

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done); // R10

    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ready) |-> r_q.done); // R10

endmodule

// File: rtl/psram_wr_gen.sv
module psram_wr_gen
    import psram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W       = 18,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned STROBE_ORDER = ORD_CE_FIRST,
    parameter bit          END_BY_CE    = 1'b0,
    parameter int unsigned WHZ_CYC      = 2,
    parameter int unsigned DW_CYC       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              wr_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n
);

    localparam int unsigned CNT_MAX = (WHZ_CYC > DW_CYC) ? WHZ_CYC : DW_CYC;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    if (WHZ_CYC < 1) begin : g_bad_whz
        $error("WHZ_CYC must be at least 1");
    end
    if (DW_CYC < 1) begin : g_bad_dw
        $error("DW_CYC must be at least 1");
    end
    if (STROBE_ORDER > ORD_TOGETHER) begin : g_bad_order
        $error("STROBE_ORDER must be 0, 1 or 2");
    end

    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    psram_wr_fsm #(
        .STROBE_ORDER (STROBE_ORDER),
        .END_BY_CE    (END_BY_CE),
        .WHZ_CYC      (WHZ_CYC),
        .DW_CYC       (DW_CYC),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .tmr_expired (tmr_expired),
        .accept      (accept),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .ce_n        (mem_ce_n),
        .we_n        (mem_we_n),
        .oe_n        (mem_oe_n),
        .drive       (mem_dq_drive),
        .ready       (req_ready),
        .done        (wr_done)
    );

    psram_wr_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    psram_wr_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .in_addr  (req_addr),
        .in_data  (req_data),
        .out_addr (mem_addr),
        .out_data (mem_dq_out)
    );

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R11

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && req_valid) |=> $stable(mem_addr)); // R2

endmodule

// File: tb/psram_wr_gen_test.sv
`timescale 1ns/1ps
module psram_wr_gen_test;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int NDUT = 3;

    localparam int CFG_ORD [NDUT] = '{0, 1, 2};
    localparam int CFG_ENDCE [NDUT] = '{0, 1, 0};
    localparam int CFG_WHZ [NDUT] = '{2, 2, 1};
    localparam int CFG_DW [NDUT] = '{3, 2, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NDUT-1:0] req_valid;
    logic [AW-1:0]   req_addr [NDUT];
    logic [DW-1:0]   req_data [NDUT];
    logic [NDUT-1:0] ready, done, drive, ce_n, we_n, oe_n;
    logic [AW-1:0]   m_addr [NDUT];
    logic [DW-1:0]   m_dq [NDUT];

    psram_wr_gen #(.ADDR_W(AW), .DATA_W(DW), .STROBE_ORDER(0), .END_BY_CE(1'b0),
                   .WHZ_CYC(2), .DW_CYC(3)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_addr(req_addr[0]),
        .req_data(req_data[0]), .req_ready(ready[0]), .wr_done(done[0]),
        .mem_addr(m_addr[0]), .mem_dq_out(m_dq[0]), .mem_dq_drive(drive[0]),
        .mem_ce_n(ce_n[0]), .mem_we_n(we_n[0]), .mem_oe_n(oe_n[0]));

    psram_wr_gen #(.ADDR_W(AW), .DATA_W(DW), .STROBE_ORDER(1), .END_BY_CE(1'b1),
                   .WHZ_CYC(2), .DW_CYC(2)) uut_we (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_addr(req_addr[1]),
        .req_data(req_data[1]), .req_ready(ready[1]), .wr_done(done[1]),
        .mem_addr(m_addr[1]), .mem_dq_out(m_dq[1]), .mem_dq_drive(drive[1]),
        .mem_ce_n(ce_n[1]), .mem_we_n(we_n[1]), .mem_oe_n(oe_n[1]));

    psram_wr_gen #(.ADDR_W(AW), .DATA_W(DW), .STROBE_ORDER(2), .END_BY_CE(1'b0),
                   .WHZ_CYC(1), .DW_CYC(1)) uut_sim (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[2]), .req_addr(req_addr[2]),
        .req_data(req_data[2]), .req_ready(ready[2]), .wr_done(done[2]),
        .mem_addr(m_addr[2]), .mem_dq_out(m_dq[2]), .mem_dq_drive(drive[2]),
        .mem_ce_n(ce_n[2]), .mem_we_n(we_n[2]), .mem_oe_n(oe_n[2]));

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input int d, input string tag);
        chk(ce_n[d] === 1'b1 && we_n[d] === 1'b1 && oe_n[d] === 1'b1 &&
            drive[d] === 1'b0 && ready[d] === 1'b1 && done[d] === 1'b0, tag, "idle pins",
            {ce_n[d], we_n[d], oe_n[d], drive[d], ready[d], done[d]}, 6'b111010);
    endtask

    // One write on copy d, checked cycle by cycle against the timeline from the requirements.
    task automatic run_write(input int d, input logic [AW-1:0] a, input logic [DW-1:0] v,
                             input bit intrude);
        int ds, te, cef, wef, cer, wer, last;
        string lead_tag;
        case (CFG_ORD[d])
            0: begin cef = 0; wef = 1; ds = 1 + CFG_WHZ[d]; lead_tag = "R4"; end
            1: begin wef = 0; cef = 1; ds = 1; lead_tag = "R5"; end
            default: begin cef = 0; wef = 0; ds = 0; lead_tag = "R6"; end
        endcase
        te   = ds + CFG_DW[d];
        cer  = CFG_ENDCE[d] ? te : te + 1;
        wer  = CFG_ENDCE[d] ? te + 1 : te;
        last = cer + 1;
        @(negedge clk);
        req_valid[d] = 1'b1;
        req_addr[d]  = a;
        req_data[d]  = v;
        @(posedge clk);
        for (int t = 0; t <= last; t++) begin
            bit ece, ewe, edr, erd;
            string stag;
            @(negedge clk);
            ece = !(t >= cef && t < cer);
            ewe = !(t >= wef && t < wer);
            edr = (t >= ds && t < te);
            erd = (t == last);
            stag = (t < ds) ? lead_tag : "R8";
            chk(ce_n[d] === ece, stag, "ce_n", ce_n[d], ece);
            chk(we_n[d] === ewe, stag, "we_n", we_n[d], ewe);
            chk(drive[d] === edr, (t < ds) ? lead_tag : "R7", "drive", drive[d], edr);
            chk(!(drive[d] === 1'b1) || (ce_n[d] === 1'b0 && we_n[d] === 1'b0), "R9",
                "drive outside overlap", {ce_n[d], we_n[d]}, 2'b00);
            chk(oe_n[d] === 1'b1, "R3", "oe_n", oe_n[d], 1);
            chk(ready[d] === erd, "R10", "ready", ready[d], erd);
            chk(done[d] === erd, "R10", "done", done[d], erd);
            chk(m_addr[d] === a, intrude ? "R2" : "R11", "addr", m_addr[d], a);
            if (edr) chk(m_dq[d] === v, "R7", "data", m_dq[d], v);
            if (t == 0) begin
                req_valid[d] = intrude;
                req_addr[d]  = ~a;
                req_data[d]  = ~v;
            end
            if (t == last - 1) req_valid[d] = 1'b0;
        end
    endtask

    typedef struct packed {
        logic [1:0]    dut;
        logic          intrude;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b0, 12'h123, 16'hA5A5},
        '{2'd1, 1'b0, 12'h456, 16'h5A5A},
        '{2'd2, 1'b0, 12'h789, 16'hFFFF},
        '{2'd0, 1'b1, 12'hFFF, 16'h0000},
        '{2'd1, 1'b1, 12'h000, 16'h1234},
        '{2'd2, 1'b1, 12'hABC, 16'h8001},
        '{2'd0, 1'b0, 12'h001, 16'hC3C3},
        '{2'd2, 1'b0, 12'h800, 16'h7FFE}
    };

    initial begin
        req_valid = '0;
        for (int i = 0; i < NDUT; i++) begin
            req_addr[i] = '0;
            req_data[i] = '0;
        end
        // R1: state while reset is held
        repeat (3) @(negedge clk);
        for (int i = 0; i < NDUT; i++) chk_idle(i, "R1");
        rst_n = 1'b1;
        // R2: no request, no activity
        repeat (5) begin
            @(negedge clk);
            for (int i = 0; i < NDUT; i++) chk(ce_n[i] === 1'b1 && we_n[i] === 1'b1, "R2",
                                               "strobes without request", {ce_n[i], we_n[i]}, 2'b11);
        end
        // Vector table walk
        for (int k = 0; k < 8; k++) begin
            run_write(int'(VECS[k].dut), VECS[k].addr, VECS[k].data, VECS[k].intrude);
            @(negedge clk);
            chk_idle(int'(VECS[k].dut), "R2");
        end
        // R1: reset landing mid-write clears the sequence at once
        @(negedge clk);
        req_valid[0] = 1'b1;
        req_addr[0]  = 12'h3C3;
        @(negedge clk);
        req_valid[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk(we_n[0] === 1'b0, "R4", "we_n low before mid-write reset", we_n[0], 0);
        rst_n = 1'b0;
        #1;
        chk_idle(0, "R1");
        chk(m_addr[0] === '0, "R1", "addr cleared", m_addr[0], 0);
        @(negedge clk);
        rst_n = 1'b1;
        // After reset the block takes a fresh request normally
        run_write(0, 12'h5A5, 16'h0F0F, 1'b0);
        run_write(1, 12'h0F0, 16'hF0F0, 1'b0);
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule